// File: doc/BRIEF.md
# Clocked 8-bit Serial Transfer Unit

This block moves one byte at a time over a three-wire synchronous link made of a shift clock, a serial data output and a serial data input. Software loads the byte to send, chooses a mode and a clock source, then pulses a start strobe. The unit produces eight shift clock cycles, or counts eight edges of an external clock. Each falling edge puts the next outgoing bit on the output, most significant bit first. Each rising edge samples the input into the low end of the same register. After the eighth rising edge the unit goes idle and raises a sticky interrupt flag. An abort ends a transfer early and raises the same flag.

The internal shift clock comes from a power-of-two divider of the core clock, in which one core cycle counts as one instruction cycle. A high select bit and a three-bit low select code choose the divide. A mode code picks transmit only, receive only, full duplex, or a free-running clock output with no transfer at all. A reset synchroniser lets reset assert at once and release on a clock edge.

Top module: `ser_xfer_unit`

## Requirements
- R1: After reset, busy_o, irq_o and cnt_o are 0, and sck_o and so_o are 1.
- R2: An accepted start strobe (ser_en_i=1, mode_i not 00) sets busy_o and clears cnt_o. While busy, cnt_o rises by one on each rising shift clock edge.
- R3: On the eighth rising edge, busy_o and cnt_o return to 0, irq_o sets and sck_o is left high. With the internal clock this happens exactly 16×H core cycles after the start edge, where H is the half period.
- R4: In modes 01 (transmit) and 11 (duplex), so_o takes the next bit of the loaded byte at each falling edge, bit 7 first. In mode 10 (receive), so_o keeps its level.
- R5: At each rising edge, the input si_i shifts into bit 0 of the register, and rx_data_o shows the register. After a transfer in modes 10 and 11, rx_data_o equals the received bits, with the first bit at bit 7. In mode 01, zeros shift in instead.
- R6: With the internal clock, the shift clock half period is 2^(11 − 2·L + S) core cycles. S is rate_hi_i and L is rate_lo_i, with codes 6 and 7 treated as 5. Half periods therefore run from 2 to 4096 cycles.
- R7: abort_i during a transfer clears busy_o and cnt_o on the next edge and sets irq_o. abort_i while idle has no effect.
- R8: irq_o stays set until an irq_clr_i pulse clears it. A set in the same cycle as a clear wins.
- R9: In mode 00 with ser_en_i=1 and the internal clock selected, sck_o toggles without end at the rate of R6. Start is ignored there, and irq_o is not raised.
- R10: With int_clk_i=0, ext_sck_i passes through a two-flop synchroniser and its edges drive the transfer, while sck_o stays 1. External edges while idle do not shift or count.
- R11: A start strobe during a transfer restarts it: cnt_o returns to 0 and a full eight edges follow.
- R12: With ser_en_i=0, start is ignored and sck_o stays 1.
- R13: While idle, idle_set_i drives so_o to idle_lvl_i on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one instruction cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_i | input | 1 | Serial enable |
| mode_i | input | 2 | 00 clock out, 01 transmit, 10 receive, 11 duplex |
| int_clk_i | input | 1 | 1 selects the internal divider, 0 the external clock |
| rate_hi_i | input | 1 | Rate high select bit |
| rate_lo_i | input | 3 | Rate low select code |
| load_i | input | 1 | Load the shift register while idle |
| load_data_i | input | 8 | Byte to transmit |
| start_i | input | 1 | Start strobe |
| abort_i | input | 1 | Abort strobe |
| irq_clr_i | input | 1 | Interrupt flag clear, write-one pulse |
| ext_sck_i | input | 1 | External shift clock |
| si_i | input | 1 | Serial data in |
| idle_set_i | input | 1 | Apply idle output level |
| idle_lvl_i | input | 1 | Idle output level |
| sck_o | output | 1 | Internal shift clock output, high when idle |
| so_o | output | 1 | Serial data out |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Transfer-end interrupt flag |
| cnt_o | output | 3 | Transfer edge counter |
| rx_data_o | output | 8 | Shift register contents |

## Verification
Each mode gets fixed and random bytes, chosen so that the sent and received patterns differ. This separates the transmit path from the receive path and shows that MSB-first order is not reversed. Random rate codes, including the reserved ones, are combined with the exact 16×H transfer length. This catches any divider or counter that is off by one. A free-running measurement of every rate code checks the full rate table. An externally clocked transfer confirms that the synchroniser path, and not the divider, is doing the counting. Abort, restart, disabled and idle-level cases each check a different way of leaving or skipping the normal eight-edge sequence.

// File: rtl/serx_pkg.sv
package serx_pkg;

  typedef enum logic [1:0] {
    MODE_CONT   = 2'b00,
    MODE_TX     = 2'b01,
    MODE_RX     = 2'b10,
    MODE_DUPLEX = 2'b11
  } serx_mode_e;

  // Largest low select code with its own rate; higher codes reuse it.
  localparam int unsigned LO_TOP_CODE = 5;

  // log2 of the shift clock half period in core cycles.
  function automatic int unsigned half_log2(input int unsigned base,
                                            input logic hi,
                                            input logic [2:0] lo);
    int unsigned eff;
    eff = {29'd0, lo};
    if (eff > LO_TOP_CODE) eff = LO_TOP_CODE;
    return base - 2 * eff + {31'd0, hi};
  endfunction

endpackage

// File: rtl/serx_rate_gen.sv
module serx_rate_gen #(
  parameter int unsigned BASE_LOG = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic       rate_hi_i,
  input  logic [2:0] rate_lo_i,
  output logic       sck_o,
  output logic       rise_o,
  output logic       fall_o
);
  import serx_pkg::*;

  localparam int unsigned DIV_W = BASE_LOG + 2;

  logic [DIV_W-1:0] cnt_q, cnt_d, limit;
  logic             sck_q, sck_d;
  logic             wrap;

  always_comb begin
    limit  = (DIV_W'(1) << half_log2(BASE_LOG, rate_hi_i, rate_lo_i)) - DIV_W'(1);
    wrap   = run_i && !restart_i && (cnt_q >= limit);
    cnt_d  = cnt_q;
    sck_d  = sck_q;
    if (!run_i || restart_i) begin
      cnt_d = '0;
      sck_d = 1'b1;
    end else if (wrap) begin
      cnt_d = '0;
      sck_d = !sck_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
    rise_o = wrap && !sck_q;
    fall_o = wrap && sck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o = sck_q;

endmodule

// File: rtl/serx_edge_sync.sv
module serx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  output logic rise_o,
  output logic fall_o
);
  // Bits 0..STAGES-1 synchronise, bit STAGES holds the previous level.
  logic [STAGES:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], ext_i};
    rise_o  = chain_q[STAGES-1] && !chain_q[STAGES];
    fall_o  = !chain_q[STAGES-1] && chain_q[STAGES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

endmodule

// File: rtl/serx_ctrl.sv
module serx_ctrl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_ok_i,
  input  logic                      abort_i,
  input  logic                      irq_clr_i,
  input  logic                      rise_i,
  input  logic                      fall_i,
  output logic                      busy_o,
  output logic [$clog2(DATA_W)-1:0] cnt_o,
  output logic                      irq_o,
  output logic                      shift_in_o,
  output logic                      shift_out_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic             busy_q, busy_d, busy_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             irq_q, irq_d, irq_en;
  logic             live, rise_ev, fall_ev, last_ev, stop;

  always_comb begin
    live    = busy_q && !start_ok_i && !abort_i;
    rise_ev = live && rise_i;
    fall_ev = live && fall_i;
    last_ev = rise_ev && (cnt_q == LAST);
    stop    = (busy_q && !start_ok_i && abort_i) || last_ev;

    busy_en = start_ok_i || stop;
    busy_d  = start_ok_i;

    cnt_en  = start_ok_i || stop || rise_ev;
    cnt_d   = (start_ok_i || stop) ? '0 : cnt_q + CNT_W'(1);

    irq_en  = stop || irq_clr_i;
    irq_d   = stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (busy_en) busy_q <= busy_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (irq_en)  irq_q  <= irq_d;
    end
  end

  assign busy_o      = busy_q;
  assign cnt_o       = cnt_q;
  assign irq_o       = irq_q;
  assign shift_in_o  = rise_ev;
  assign shift_out_o = fall_ev;

endmodule

// File: rtl/serx_shifter.sv
module serx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_in_i,
  input  logic              shift_out_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              si_i,
  input  logic              idle_set_i,
  input  logic              idle_lvl_i,
  output logic              so_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sh_en;
  logic              so_q, so_d, so_en;

  always_comb begin
    sh_en = 1'b0;
    sh_d  = sh_q;
    if (!busy_i && load_i) begin
      sh_en = 1'b1;
      sh_d  = load_data_i;
    end else if (shift_in_i) begin
      sh_en = 1'b1;
      sh_d  = {sh_q[DATA_W-2:0], rx_en_i & si_i};
    end

    so_en = 1'b0;
    so_d  = so_q;
    if (shift_out_i && tx_en_i) begin
      so_en = 1'b1;
      so_d  = sh_q[DATA_W-1];
    end else if (!busy_i && idle_set_i) begin
      so_en = 1'b1;
      so_d  = idle_lvl_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      so_q <= 1'b1;
    end else begin
      if (sh_en) sh_q <= sh_d;
      if (so_en) so_q <= so_d;
    end
  end

  assign so_o   = so_q;
  assign data_o = sh_q;

endmodule

// File: rtl/ser_xfer_unit.sv
module ser_xfer_unit #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BASE_LOG    = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_en_i,
  input  logic [1:0]                mode_i,
  input  logic                      int_clk_i,
  input  logic                      rate_hi_i,
  input  logic [2:0]                rate_lo_i,
  input  logic                      load_i,
  input  logic [DATA_W-1:0]         load_data_i,
  input  logic                      start_i,
  input  logic                      abort_i,
  input  logic                      irq_clr_i,
  input  logic                      ext_sck_i,
  input  logic                      si_i,
  input  logic                      idle_set_i,
  input  logic                      idle_lvl_i,
  output logic                      sck_o,
  output logic                      so_o,
  output logic                      busy_o,
  output logic                      irq_o,
  output logic [$clog2(DATA_W)-1:0] cnt_o,
  output logic [DATA_W-1:0]         rx_data_o
);
  import serx_pkg::*;

  // Reset: asserts asynchronously, releases on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  serx_mode_e mode;
  logic       cont_run, start_ok, div_run;
  logic       int_sck, int_rise, int_fall;
  logic       ext_rise, ext_fall;
  logic       edge_rise, edge_fall;
  logic       busy, shift_in, shift_out;

  always_comb begin
    mode      = serx_mode_e'(mode_i);
    cont_run  = ser_en_i && int_clk_i && (mode == MODE_CONT);
    start_ok  = start_i && ser_en_i && (mode != MODE_CONT);
    div_run   = int_clk_i && (busy || cont_run);
    edge_rise = int_clk_i ? int_rise : ext_rise;
    edge_fall = int_clk_i ? int_fall : ext_fall;
  end

  serx_rate_gen #(.BASE_LOG(BASE_LOG)) u_rate (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run_i     (div_run),
    .restart_i (start_ok),
    .rate_hi_i (rate_hi_i),
    .rate_lo_i (rate_lo_i),
    .sck_o     (int_sck),
    .rise_o    (int_rise),
    .fall_o    (int_fall)
  );

  serx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ext_i  (ext_sck_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  serx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_ok_i  (start_ok),
    .abort_i     (abort_i),
    .irq_clr_i   (irq_clr_i),
    .rise_i      (edge_rise),
    .fall_i      (edge_fall),
    .busy_o      (busy),
    .cnt_o       (cnt_o),
    .irq_o       (irq_o),
    .shift_in_o  (shift_in),
    .shift_out_o (shift_out)
  );

  serx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .busy_i      (busy),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .shift_in_i  (shift_in),
    .shift_out_i (shift_out),
    .tx_en_i     (mode_i[0]),
    .rx_en_i     (mode_i[1]),
    .si_i        (si_i),
    .idle_set_i  (idle_set_i),
    .idle_lvl_i  (idle_lvl_i),
    .so_o        (so_o),
    .data_o      (rx_data_o)
  );

  assign busy_o = busy;
  assign sck_o  = int_sck;

endmodule

// File: rtl/ser_xfer_unit_chk.sv
module ser_xfer_unit_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_en_i,
  input logic [1:0]       mode_i,
  input logic             int_clk_i,
  input logic             start_i,
  input logic             abort_i,
  input logic             irq_clr_i,
  input logic             sck_o,
  input logic             busy_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_o
);
  logic cont_w;
  assign cont_w = ser_en_i && int_clk_i && (mode_i == 2'b00);

  // R2: the counter is zero whenever no transfer is running
  p_cnt_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> cnt_o == '0);

  // R2: during a transfer the counter holds or steps by one
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i && !abort_i) |=>
      (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1) || !busy_o));

  // R3: the end of a transfer always leaves the flag set
  p_end_sets_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> irq_o);

  // R7: abort ends a running transfer on the next edge
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && abort_i && !start_i) |=> (!busy_o && irq_o && cnt_o == '0));

  // R8: the flag holds until cleared
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);

  // R8: a clear while idle drops the flag
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_clr_i && !busy_o) |=> !irq_o);

  // R12: with no transfer and no clock-out mode the clock parks high
  p_sck_park_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !cont_w) |=> (busy_o || cont_w || sck_o));

endmodule

bind ser_xfer_unit ser_xfer_unit_chk #(.CNT_W($clog2(DATA_W))) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_en_i  (ser_en_i),
  .mode_i    (mode_i),
  .int_clk_i (int_clk_i),
  .start_i   (start_i),
  .abort_i   (abort_i),
  .irq_clr_i (irq_clr_i),
  .sck_o     (sck_o),
  .busy_o    (busy_o),
  .irq_o     (irq_o),
  .cnt_o     (cnt_o)
);

// File: tb/ser_xfer_unit_tb_top.sv
`timescale 1ns/1ps
module ser_xfer_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_en_i = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic       int_clk_i = 1'b1;
  logic       rate_hi_i = 1'b0;
  logic [2:0] rate_lo_i = 3'd5;
  logic       load_i = 1'b0;
  logic [7:0] load_data_i = 8'h00;
  logic       start_i = 1'b0;
  logic       abort_i = 1'b0;
  logic       irq_clr_i = 1'b0;
  logic       ext_sck_i = 1'b1;
  logic       si_i = 1'b0;
  logic       idle_set_i = 1'b0;
  logic       idle_lvl_i = 1'b1;
  logic       sck_o, so_o, busy_o, irq_o;
  logic [2:0] cnt_o;
  logic [7:0] rx_data_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ser_xfer_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ser_en_i(ser_en_i), .mode_i(mode_i),
    .int_clk_i(int_clk_i), .rate_hi_i(rate_hi_i), .rate_lo_i(rate_lo_i),
    .load_i(load_i), .load_data_i(load_data_i), .start_i(start_i),
    .abort_i(abort_i), .irq_clr_i(irq_clr_i), .ext_sck_i(ext_sck_i),
    .si_i(si_i), .idle_set_i(idle_set_i), .idle_lvl_i(idle_lvl_i),
    .sck_o(sck_o), .so_o(so_o), .busy_o(busy_o), .irq_o(irq_o),
    .cnt_o(cnt_o), .rx_data_o(rx_data_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int exp_half(input bit h, input logic [2:0] lo);
    int l;
    l = (lo > 3'd5) ? 5 : int'(lo);
    return 1 << (11 - 2 * l + (h ? 1 : 0));
  endfunction

  function automatic logic [7:0] exp_rx(input logic [1:0] m, input logic [7:0] si_b);
    return m[1] ? si_b : 8'h00;
  endfunction

  task automatic pulse_start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr_i = 1'b1; tick(); irq_clr_i = 1'b0; tick();
  endtask

  task automatic wait_done(output int cyc);
    int k;
    k = 1;
    while (busy_o && k < 20000) begin tick(); k++; end
    cyc = k - 1;
  endtask

  task automatic xfer_int(input logic [1:0] m, input bit h, input logic [2:0] lo,
                          input logic [7:0] tx, input logic [7:0] si_b);
    int half, k, rises, falls, cnt_bad;
    bit prev, done;
    logic [7:0] so_bits;
    logic base_so;
    half = exp_half(h, lo);
    ser_en_i = 1'b1; int_clk_i = 1'b1; mode_i = m;
    rate_hi_i = h; rate_lo_i = lo;
    load_i = 1'b1; load_data_i = tx; tick(); load_i = 1'b0; tick();
    base_so = so_o;
    pulse_start();
    k = 1; rises = 0; falls = 0; cnt_bad = 0; prev = 1'b1; done = 1'b0;
    so_bits = '0;
    while (!done) begin
      if (sck_o && !prev) begin
        rises++;
        so_bits = {so_bits[6:0], so_o};
      end
      if (!sck_o && prev) begin
        falls++;
        if (falls <= 8) si_i = si_b[3'(8 - falls)];
      end
      if (int'(cnt_o) != rises % 8) cnt_bad++;
      prev = sck_o;
      if (!busy_o || k > 20000) done = 1'b1;
      else begin tick(); k++; end
    end
    chk(k - 1 == 16 * half, "R3 transfer length", k - 1, 16 * half);
    chk(rises == 8, "R3 rising edges", rises, 8);
    chk(cnt_bad == 0, "R2 counter tracks edges", cnt_bad, 0);
    chk(irq_o == 1'b1 && cnt_o == 3'd0, "R3 flag set counter clear", int'(irq_o), 1);
    chk(sck_o == 1'b1, "R3 clock parked high", int'(sck_o), 1);
    chk(so_bits == (m[0] ? tx : {8{base_so}}), "R4 output bits", int'(so_bits),
        int'(m[0] ? tx : {8{base_so}}));
    chk(rx_data_o == exp_rx(m, si_b), "R5 received byte", int'(rx_data_o),
        int'(exp_rx(m, si_b)));
    clear_irq();
    chk(irq_o == 1'b0, "R8 flag cleared", int'(irq_o), 0);
  endtask

  task automatic measure_period(input bit h, input logic [2:0] lo);
    int n;
    bit prev;
    ser_en_i = 1'b1; int_clk_i = 1'b1; rate_hi_i = h; rate_lo_i = lo;
    mode_i = 2'b00;
    prev = sck_o; n = 0;
    while (!(sck_o && !prev) && n < 20000) begin prev = sck_o; tick(); n++; end
    prev = sck_o; tick(); n = 1;
    while (!(sck_o && !prev) && n < 20000) begin prev = sck_o; tick(); n++; end
    chk(n == 2 * exp_half(h, lo), "R6 clock period", n, 2 * exp_half(h, lo));
    mode_i = 2'b01; tick(); tick();
  endtask

  initial begin : watchdog
    #(5ns * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int cyc;
    logic [7:0] rx_keep;
    logic [7:0] so_bits;
    bit sck_bad;
    void'($urandom(32'd1234));
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1
    chk(!busy_o && !irq_o && cnt_o == 3'd0, "R1 reset idle", int'(busy_o), 0);
    chk(sck_o && so_o, "R1 reset lines high", int'({sck_o, so_o}), 3);

    // R13 idle level
    idle_set_i = 1'b1; idle_lvl_i = 1'b0; tick(); idle_set_i = 1'b0;
    chk(so_o == 1'b0, "R13 idle level low", int'(so_o), 0);
    idle_set_i = 1'b1; idle_lvl_i = 1'b1; tick(); idle_set_i = 1'b0;
    chk(so_o == 1'b1, "R13 idle level high", int'(so_o), 1);

    // R12 disabled
    ser_en_i = 1'b0; mode_i = 2'b11; pulse_start(); tick();
    chk(!busy_o, "R12 start ignored when disabled", int'(busy_o), 0);
    repeat (10) tick();
    chk(sck_o, "R12 clock stays high", int'(sck_o), 1);

    // Directed transfers: R2 R3 R4 R5
    xfer_int(2'b11, 1'b0, 3'd5, 8'hA5, 8'h3C);
    xfer_int(2'b01, 1'b0, 3'd5, 8'h81, 8'hFF);
    xfer_int(2'b10, 1'b1, 3'd5, 8'h5A, 8'hC3);
    xfer_int(2'b11, 1'b0, 3'd3, 8'h01, 8'h80);
    xfer_int(2'b11, 1'b1, 3'd7, 8'hF0, 8'h0F);

    // R6 every rate code, R9 free-running clock
    for (int hb = 0; hb < 2; hb++)
      for (int lc = 0; lc < 8; lc++)
        measure_period(hb[0], 3'(lc));
    ser_en_i = 1'b1; mode_i = 2'b00; rate_hi_i = 1'b0; rate_lo_i = 3'd5;
    pulse_start(); tick();
    chk(!busy_o, "R9 start ignored in clock mode", int'(busy_o), 0);
    repeat (40) tick();
    chk(!irq_o && cnt_o == 3'd0, "R9 no flag in clock mode", int'(irq_o), 0);
    mode_i = 2'b01; tick(); tick();

    // R7 abort
    int_clk_i = 1'b1; mode_i = 2'b11; rate_hi_i = 1'b1; rate_lo_i = 3'd4;
    pulse_start(); repeat (40) tick();
    chk(busy_o && cnt_o != 3'd0, "R7 transfer underway", int'(cnt_o), 1);
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    chk(!busy_o && cnt_o == 3'd0 && irq_o, "R7 abort ends transfer",
        int'({busy_o, irq_o}), 1);
    tick(); tick();
    chk(sck_o, "R7 clock parks after abort", int'(sck_o), 1);
    clear_irq();
    abort_i = 1'b1; tick(); abort_i = 1'b0; tick();
    chk(!irq_o && !busy_o, "R7 idle abort no effect", int'(irq_o), 0);

    // R11 restart
    rate_hi_i = 1'b0; rate_lo_i = 3'd5;
    pulse_start();
    cyc = 0;
    while (cnt_o != 3'd3 && cyc < 1000) begin tick(); cyc++; end
    pulse_start();
    chk(busy_o && cnt_o == 3'd0, "R11 restart clears counter", int'(cnt_o), 0);
    wait_done(cyc);
    chk(cyc == 32, "R11 full length after restart", cyc, 32);
    clear_irq();

    // R10 external clock
    int_clk_i = 1'b0; mode_i = 2'b11;
    load_i = 1'b1; load_data_i = 8'h6B; tick(); load_i = 1'b0;
    pulse_start();
    sck_bad = 1'b0; so_bits = '0;
    for (int b = 0; b < 8; b++) begin
      ext_sck_i = 1'b0; si_i = 8'hD2 >> (7 - b);
      repeat (4) begin tick(); if (!sck_o) sck_bad = 1'b1; end
      so_bits = {so_bits[6:0], so_o};
      ext_sck_i = 1'b1;
      repeat (4) begin tick(); if (!sck_o) sck_bad = 1'b1; end
    end
    chk(!busy_o && irq_o, "R10 external transfer ends", int'({busy_o, irq_o}), 1);
    chk(rx_data_o == 8'hD2, "R10 external receive", int'(rx_data_o), 8'hD2);
    chk(so_bits == 8'h6B, "R10 external transmit", int'(so_bits), 8'h6B);
    chk(!sck_bad, "R10 clock output stays high", int'(sck_bad), 0);
    clear_irq();
    rx_keep = rx_data_o;
    for (int b = 0; b < 3; b++) begin
      ext_sck_i = 1'b0; si_i = 1'b1; repeat (4) tick();
      ext_sck_i = 1'b1; repeat (4) tick();
    end
    chk(rx_data_o == rx_keep && cnt_o == 3'd0 && !busy_o,
        "R10 idle edges ignored", int'(rx_data_o), int'(rx_keep));

    // Random transfers (R2 R3 R4 R5 R6)
    for (int t = 0; t < 30; t++) begin
      logic [1:0] m;
      m = 2'(1 + ($urandom % 3));
      xfer_int(m, 1'($urandom % 2), 3'(4 + ($urandom % 4)),
               8'($urandom), 8'($urandom));
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule